// File: doc/BRIEF.md
# Temperature Sensor Conversion Controller

This block is a register-mapped controller that sits in front of an on-die temperature sensor's ADC. Software powers the sensor up through a power register. It waits out a settling window and then writes a trigger. The controller then gathers one, two, four or eight raw 12-bit codes from the converter. It reduces them to a single truncated mean, or to the last raw code when averaging is not selected, and latches that value into a result register. A completion flag is set at the same time.

A window comparator can check every new result against a programmable lower and upper code. A result that lies strictly outside the window sets a compare flag. The compare flag drives a single interrupt line through a mask bit. Both flags are cleared by writing ones to a clear register.

The analog converter is modelled as a sample port with a one-cycle valid strobe. The register bus is a plain single-cycle write port with a combinational read port. Only single-scan operation is offered.

Top module: `thermal_conv_ctrl`

## Requirements
- R1: After reset every readable register reads 0, the busy bit is 0 and `irq` is low.
- R2: In the power register (offset 0x00), bit 2 is the SoC-side enable, bit 1 is the ADC power-down and bit 0 is the sensor enable. A write stores bit 0 as 1 only if bit 2 of the same write is 1 or the stored bit 2 was already 1. Otherwise bit 0 is stored as 0.
- R3: The sensor counts as active when sensor enable = 1, SoC enable = 1 and power-down = 0. A settle counter is cleared whenever the sensor is not active. A trigger (bit 0 of a write to offset 0x04) is ignored until the sensor has been active for `SETTLE_CYCLES` clock cycles.
- R4: The busy bit (bit 0 at offset 0x14) becomes 1 in the cycle after an accepted trigger. It stays 1 until the cycle after the last sample of the conversion is accepted. Samples are accepted only while busy.
- R5: The config field bits[1:0] at offset 0x08 (value k) sets the sample count to 2^k; k = 3 gives eight samples. With config bit 9 = 1 the result is the sum of the samples shifted right by k, with truncation.
- R6: With config bit 9 = 0 the result is the raw code of the last sample of the conversion.
- R7: The result register (offset 0x10, bits[11:0]) changes only in the cycle after the final sample of a conversion.
- R8: Completion sets bit 0 of the flag register (offset 0x30). Writing 1 to bit 0 of offset 0x38 clears it.
- R9: When bit 0 at offset 0x18 is 1, a result below the lower limit (0x1C) or above the upper limit (0x20) sets flag bit 1. A result equal to either limit, or any result while compare is disabled, leaves flag bit 1 unchanged. Writing 1 to bit 1 of offset 0x38 clears it.
- R10: `irq` equals flag bit 1 AND interrupt-enable bit 1 (offset 0x34).
- R11: A trigger written while busy is ignored and does not restart the sample count.
- R12: When a flag is set and cleared in the same cycle, the set wins.
- R13: Config bit 4 (continuous scan) always reads 0; only bits 9 and 1:0 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| smp_valid | input | 1 | One-cycle strobe for a new converter code |
| smp_code | input | CODE_W | Raw converter code |
| irq | output | 1 | Masked compare interrupt |

## Verification
The hardest situation to reach is a flag that is set and cleared in the same cycle. The bench produces it by driving the final sample strobe and a clear-register write on the same clock edge, with compare enabled and an out-of-range code. A second difficult case is a trigger that arrives inside the settling window. The bench lands it just after power-up, and again after a power-down and re-enable, to show that the counter restarts. A behavioural model that keeps the samples in a queue mirrors every register and `irq` on each cycle.

// File: rtl/thermal_conv_ctrl.sv
module thermal_conv_ctrl #(
  parameter int CODE_W        = 12,
  parameter int SETTLE_CYCLES = 2880,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              irq
);
  localparam int ACC_W = CODE_W + 3;
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_PWR = 'h00, A_TRIG = 'h04, A_CFG = 'h08, A_RES = 'h10,
    A_BUSY = 'h14, A_CMP = 'h18, A_LO = 'h1C, A_HI = 'h20, A_FLG = 'h30, A_IEN = 'h34, A_CLR = 'h38;

  logic              soc_en, pd, sens_en;
  logic [SET_W-1:0]  settle_cnt;
  logic [1:0]        cfg_log2, run_log2;
  logic              cfg_avg, run_avg;
  logic              busy;
  logic [2:0]        smp_cnt;
  logic [ACC_W-1:0]  acc;
  logic [CODE_W-1:0] result, lo_lim, hi_lim;
  logic              cmp_en, adf, cmpf;
  logic [1:0]        ien;

  wire active = sens_en & soc_en & ~pd;
  wire ready  = settle_cnt == SET_W'(SETTLE_CYCLES);
  wire wr_pwr = bus_wr && bus_addr == A_PWR;
  wire wr_clr = bus_wr && bus_addr == A_CLR;
  wire start  = bus_wr && bus_addr == A_TRIG && bus_wdata[0] && ready && !busy;
  wire take   = busy && smp_valid;
  wire [2:0] last_idx = ~(3'b111 << run_log2);
  wire done   = take && smp_cnt == last_idx;
  wire [ACC_W-1:0]  sum = acc + ACC_W'(smp_code);
  wire [ACC_W-1:0]  avg = sum >> run_log2;
  wire [CODE_W-1:0] new_code = run_avg ? avg[CODE_W-1:0] : smp_code;
  wire oor = cmp_en && (new_code < lo_lim || new_code > hi_lim);

  assign irq = cmpf & ien[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soc_en <= 1'b0; pd <= 1'b0; sens_en <= 1'b0;
      settle_cnt <= '0;
      cfg_log2 <= '0; cfg_avg <= 1'b0; run_log2 <= '0; run_avg <= 1'b0;
      busy <= 1'b0; smp_cnt <= '0; acc <= '0; result <= '0;
      lo_lim <= '0; hi_lim <= '0; cmp_en <= 1'b0; ien <= '0;
      adf <= 1'b0; cmpf <= 1'b0;
    end else begin
      if (!active) settle_cnt <= '0;
      else if (!ready) settle_cnt <= settle_cnt + 1'b1;

      if (wr_pwr) begin
        soc_en  <= bus_wdata[2];
        pd      <= bus_wdata[1];
        sens_en <= bus_wdata[0] & (bus_wdata[2] | soc_en);
      end
      if (bus_wr && bus_addr == A_CFG) begin
        cfg_log2 <= bus_wdata[1:0];
        cfg_avg  <= bus_wdata[9];
      end
      if (bus_wr && bus_addr == A_CMP) cmp_en <= bus_wdata[0];
      if (bus_wr && bus_addr == A_LO)  lo_lim <= bus_wdata[CODE_W-1:0];
      if (bus_wr && bus_addr == A_HI)  hi_lim <= bus_wdata[CODE_W-1:0];
      if (bus_wr && bus_addr == A_IEN) ien    <= bus_wdata[1:0];

      if (start) begin
        busy <= 1'b1; smp_cnt <= '0; acc <= '0;
        run_log2 <= cfg_log2; run_avg <= cfg_avg;
      end else if (done) begin
        busy <= 1'b0; result <= new_code;
      end else if (take) begin
        smp_cnt <= smp_cnt + 1'b1; acc <= sum;
      end

      adf  <= done | (adf & ~(wr_clr & bus_wdata[0]));
      cmpf <= (done & oor) | (cmpf & ~(wr_clr & bus_wdata[1]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PWR:  bus_rdata[2:0] = {soc_en, pd, sens_en};
      A_CFG:  begin bus_rdata[9] = cfg_avg; bus_rdata[1:0] = cfg_log2; end
      A_RES:  bus_rdata[CODE_W-1:0] = result;
      A_BUSY: bus_rdata[0] = busy;
      A_CMP:  bus_rdata[0] = cmp_en;
      A_LO:   bus_rdata[CODE_W-1:0] = lo_lim;
      A_HI:   bus_rdata[CODE_W-1:0] = hi_lim;
      A_FLG:  bus_rdata[1:0] = {cmpf, adf};
      A_IEN:  bus_rdata[1:0] = ien;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/thermal_conv_ctrl_chk.sv
module thermal_conv_ctrl_chk #(
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              soc_en,
  input logic              sens_en,
  input logic              busy,
  input logic              ready,
  input logic              done,
  input logic              adf,
  input logic              irq,
  input logic [CODE_W-1:0] result
);
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == ADDR_W'('h00) && !bus_wdata[2] && !soc_en) |=> !sens_en); // R2
  AST_START_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ready)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done |=> adf); // R12
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(result)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(done) || $past(bus_wr))); // R10
endmodule

bind thermal_conv_ctrl thermal_conv_ctrl_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .soc_en(soc_en), .sens_en(sens_en), .busy(busy), .ready(ready), .done(done),
  .adf(adf), .irq(irq), .result(result)
);

// File: tb/thermal_conv_ctrl_tb.sv
module thermal_conv_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 20;
  localparam int CW     = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic smp_valid = 1'b0;
  logic [CW-1:0] smp_code = '0;
  logic irq;

  always #(CLK_P/2) clk = ~clk;

  thermal_conv_ctrl #(.CODE_W(CW), .SETTLE_CYCLES(SETTLE), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .smp_valid(smp_valid), .smp_code(smp_code), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference model
  bit m_soc, m_pd, m_en, m_busy, m_sel, m_rsel, m_cmpen, m_adf, m_cmpf;
  int m_settle, m_log2, m_rlog2, m_lo, m_hi, m_ien, m_res;
  int q[$];
  int s_sum, s_res;
  bit s_done, s_oor, s_ready, s_act, s_clr0, s_clr1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_soc = 0; m_pd = 0; m_en = 0; m_busy = 0; m_sel = 0; m_rsel = 0; m_cmpen = 0;
      m_adf = 0; m_cmpf = 0; m_settle = 0; m_log2 = 0; m_rlog2 = 0; m_lo = 0; m_hi = 0;
      m_ien = 0; m_res = 0; q.delete();
    end else begin
      s_done = 0; s_oor = 0;
      if (m_busy && smp_valid) begin
        q.push_back(int'(smp_code));
        if (q.size() == (1 << m_rlog2)) begin
          s_done = 1;
          s_sum = 0;
          foreach (q[i]) s_sum += q[i];
          s_res = m_rsel ? (s_sum >> m_rlog2) : int'(smp_code);
          s_oor = m_cmpen && (s_res < m_lo || s_res > m_hi);
        end
      end
      s_ready = (m_settle == SETTLE);
      s_act = m_en && m_soc && !m_pd;
      if (!s_act) m_settle = 0;
      else if (m_settle < SETTLE) m_settle++;
      s_clr0 = bus_wr && bus_addr == 8'h38 && bus_wdata[0];
      s_clr1 = bus_wr && bus_addr == 8'h38 && bus_wdata[1];
      if (bus_wr && bus_addr == 8'h04 && bus_wdata[0] && s_ready && !m_busy) begin
        m_busy = 1; q.delete(); m_rlog2 = m_log2; m_rsel = m_sel;
      end else if (s_done) begin
        m_busy = 0; m_res = s_res;
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h00: begin m_en = bus_wdata[0] && (bus_wdata[2] || m_soc); m_soc = bus_wdata[2]; m_pd = bus_wdata[1]; end
          8'h08: begin m_log2 = int'(bus_wdata[1:0]); m_sel = bus_wdata[9]; end
          8'h18: m_cmpen = bus_wdata[0];
          8'h1C: m_lo = int'(bus_wdata[11:0]);
          8'h20: m_hi = int'(bus_wdata[11:0]);
          8'h34: m_ien = int'(bus_wdata[1:0]);
          default: ;
        endcase
      end
      m_adf  = s_done || (m_adf && !s_clr0);
      m_cmpf = (s_done && s_oor) || (m_cmpf && !s_clr1);
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return {29'd0, m_soc, m_pd, m_en};
      8'h08: return (32'(m_sel) << 9) | 32'(m_log2);
      8'h10: return 32'(m_res);
      8'h14: return 32'(m_busy);
      8'h18: return 32'(m_cmpen);
      8'h1C: return 32'(m_lo);
      8'h20: return 32'(m_hi);
      8'h30: return {30'd0, m_cmpf, m_adf};
      8'h34: return 32'(m_ien);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2 model pwr";
      8'h08: return "R13 model cfg";
      8'h10: return "R5 model result";
      8'h14: return "R4 model busy";
      8'h30: return "R8 model flags";
      default: return "R9 model reg";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      #(CLK_P/4);
      check(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
      check("R10 model irq", 32'(irq), 32'(m_cmpf && m_ien[1]));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic smp(int c);
    @(negedge clk); smp_valid = 1; smp_code = CW'(c);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic conv1(int c);
    wr(8'h04, 1); smp(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int codes[8] = '{1000, 1001, 1003, 1007, 1010, 1011, 1013, 1020};
    int tot;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (codes[i]) ;
    rd_chk("R1 pwr", 8'h00, 0); rd_chk("R1 cfg", 8'h08, 0); rd_chk("R1 result", 8'h10, 0);
    rd_chk("R1 busy", 8'h14, 0); rd_chk("R1 flags", 8'h30, 0); rd_chk("R1 ien", 8'h34, 0);
    check("R1 irq", 32'(irq), 0);
    // R2 enable gating
    wr(8'h00, 1); rd_chk("R2 en without soc", 8'h00, 0);
    wr(8'h00, 4); wr(8'h00, 1); rd_chk("R2 en with soc already set", 8'h00, 1);
    wr(8'h00, 0); wr(8'h00, 5); rd_chk("R2 en with soc same write", 8'h00, 5);
    // R3 trigger during settle
    wr(8'h08, 32'h203);
    wr(8'h04, 1); rd_chk("R3 early trigger ignored", 8'h14, 0);
    repeat (SETTLE + 2) @(negedge clk);
    smp(55);
    wr(8'h04, 1); rd_chk("R3 R4 trigger after settle", 8'h14, 1);
    // R5 eight-sample average, R7, R11
    tot = 0;
    for (int i = 0; i < 7; i++) begin smp(codes[i]); tot += codes[i]; end
    rd_chk("R7 result held mid conversion", 8'h10, 0);
    rd_chk("R4 busy mid conversion", 8'h14, 1);
    wr(8'h04, 1);
    smp(codes[7]); tot += codes[7];
    rd_chk("R11 R4 done after eighth sample", 8'h14, 0);
    rd_chk("R5 averaged result", 8'h10, 32'(tot >> 3));
    rd_chk("R8 completion flag", 8'h30, 1);
    wr(8'h38, 1); rd_chk("R8 flag cleared", 8'h30, 0);
    // R6 raw output
    wr(8'h08, 3); wr(8'h04, 1);
    for (int i = 0; i < 7; i++) smp(300 + i);
    smp(777);
    rd_chk("R6 raw last sample", 8'h10, 777);
    // R5 two samples
    wr(8'h08, 32'h201); wr(8'h04, 1); smp(5); smp(8);
    rd_chk("R5 two-sample average", 8'h10, 6);
    // R13
    wr(8'h08, 32'h213); rd_chk("R13 continuous bit reads 0", 8'h08, 32'h203);
    // R9 R10 compare window
    wr(8'h08, 32'h200); wr(8'h1C, 100); wr(8'h20, 200); wr(8'h18, 1); wr(8'h34, 2);
    wr(8'h38, 3);
    conv1(150); rd_chk("R9 in range", 8'h30, 1);
    conv1(100); rd_chk("R9 equal lower", 8'h30, 1);
    conv1(200); rd_chk("R9 equal upper", 8'h30, 1);
    check("R10 irq low in range", 32'(irq), 0);
    conv1(201); rd_chk("R9 above upper", 8'h30, 3);
    check("R10 irq high", 32'(irq), 1);
    wr(8'h38, 2); check("R10 irq after clear", 32'(irq), 0);
    conv1(99); rd_chk("R9 below lower", 8'h30, 3);
    wr(8'h34, 0); check("R10 irq masked", 32'(irq), 0);
    wr(8'h34, 2); check("R10 irq unmasked", 32'(irq), 1);
    wr(8'h38, 3); wr(8'h18, 0);
    conv1(4000); rd_chk("R9 compare disabled", 8'h30, 1);
    // R12 set wins over clear
    wr(8'h18, 1); wr(8'h38, 3); wr(8'h04, 1);
    @(negedge clk);
    smp_valid = 1; smp_code = 4000; bus_wr = 1; bus_addr = 8'h38; bus_wdata = 3;
    @(negedge clk); smp_valid = 0; bus_wr = 0;
    rd_chk("R12 set beats clear", 8'h30, 3);
    // R3 power-down restarts settle
    wr(8'h00, 7); wr(8'h00, 5);
    wr(8'h04, 1); rd_chk("R3 trigger after re-power ignored", 8'h14, 0);
    repeat (SETTLE + 2) @(negedge clk);
    wr(8'h04, 1); rd_chk("R3 trigger after re-settle", 8'h14, 1);
    smp(150);
    rd_chk("R4 idle after one sample", 8'h14, 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule